// File: doc/BRIEF.md
# Programmable Square-Wave Interrupt Output

This block drives a single interrupt/strobe pin from a tick that is derived from the bus clock by a fixed divisor. One configuration register holds a 16-bit reload count, a 3-bit mode field and a diagnostic bit. It also holds a read-only bit that shows the live output level. When the mode field selects toggle operation, the output inverts after every COUNT+1 ticks. The result is a square wave whose full period is 2*(COUNT+1) ticks.

Software can time the rising edges of the wave against a reference clock of known rate. Because the reload formula is fixed, that timing gives the bus clock frequency. A second register decides whether the level reaches the pin: it holds an enable bit and a direction bit. Every write to the configuration register reloads the down-counter and restarts the wave from low. Writing all zeros returns the generator to its power-on state.

Top module: `intout_gen`

## Requirements
- R1: After reset both registers read as zero, `pin_oe` is 0 and `pin_o` is 0.
- R2: With mode field bits [18:16] = 3'b111, the first inversion after a configuration write (to high) comes DIV*(COUNT+1) clock cycles after the write edge. Each later inversion follows the previous one by the same interval.
- R3: A tick occurs once every DIV clock cycles, so the full toggle period is 2*DIV*(COUNT+1) clock cycles for every COUNT, including COUNT = 0.
- R4: Any mode value other than 3'b111 holds the generated level low and freezes the down-counter.
- R5: Diagnostic bit [19] set forces the output level high, whatever the mode and count.
- R6: `pin_oe` is 1 only when pin-control bit [0] (enable) and bit [1] (direction, 1 = output) are both set. While `pin_oe` is 0, `pin_o` is 0; while it is 1, `pin_o` follows the output level.
- R7: Writing all zeros to the configuration register returns the generator to its reset state: the level is low and the register reads zero.
- R8: Configuration bit [20] reads the current output level, including the diagnostic force. Its value in a write has no effect.
- R9: Reads with `rd_sel` = 0 return the count at [15:0], the mode at [18:16] and the diagnostic bit at [19]. Reads with `rd_sel` = 1 return the enable at [0] and the direction at [1]. All other bits read as zero.
- R10: A configuration write in the middle of a period drives the level low at once and reloads the counter. The next inversion then comes a full DIV*(COUNT+1) cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 pin control |
| wr_data | input | DATA_W (32) | Write data |
| rd_sel | input | 1 | Read target: 0 configuration, 1 pin control |
| rd_data | output | DATA_W (32) | Read data (combinational) |
| pin_o | output | 1 | Gated output level |
| pin_oe | output | 1 | Pin driver enable |

## Verification
The bench builds the block with DIV = 3 and COUNT_W = 16. An odd divisor makes the prescaler wrap at a point that is not a power of two, so an off-by-one in the tick logic shows up as a cycle error. This is checked against the exact DIV*(COUNT+1) half-period for COUNT values 0, 1, 4 and 63. These settings keep even the COUNT = 63 wave to a few hundred cycles. Two non-toggle mode codes, a restart in the middle of a period and all four enable/direction combinations are covered at the pin.

// File: rtl/intout_pkg.sv
package intout_pkg;
   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_TOGGLE = 3'b111;

   typedef logic [MODE_W-1:0] mode_t;

   typedef struct packed {
      logic dir_out;
      logic enable;
   } pinctl_t;

   typedef enum logic {
      SEL_CFG = 1'b0,
      SEL_PIN = 1'b1
   } regsel_e;
endpackage

// File: rtl/intout_prescale.sv
module intout_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_nodiv
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ restart;
         assign tick_o    = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (restart || pre_q == LAST) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end

         assign tick_o = (pre_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/intout_wavegen.sv
module intout_wavegen #(
   parameter int COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [COUNT_W-1:0] count_load,
   input  logic [COUNT_W-1:0] count_cfg,
   input  logic               toggle_en,
   input  logic               diag,
   input  logic               tick,
   output logic               level_q,
   output logic [COUNT_W-1:0] cnt_q,
   output logic               level_out
);
   logic expire;
   assign expire = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         cnt_q   <= '0;
      end else if (restart) begin
         level_q <= 1'b0;
         cnt_q   <= count_load;
      end else if (toggle_en && tick) begin
         if (expire) begin
            level_q <= ~level_q;
            cnt_q   <= count_cfg;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign level_out = level_q | diag;
endmodule

// File: rtl/intout_regs.sv
module intout_regs
   import intout_pkg::*;
#(
   parameter int COUNT_W = 16,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_sel,
   input  logic               level_now,
   output logic [DATA_W-1:0]  rd_data,
   output logic               cfg_wr,
   output logic [COUNT_W-1:0] count_load,
   output logic [COUNT_W-1:0] count_q,
   output logic               toggle_en,
   output logic               diag_q,
   output pinctl_t            pin_q
);
   localparam int MODE_LSB  = COUNT_W;
   localparam int DIAG_BIT  = COUNT_W + MODE_W;
   localparam int STATE_BIT = DIAG_BIT + 1;
   localparam int USED_W    = STATE_BIT + 1;

   mode_t mode_q;
   logic  pin_wr;

   assign cfg_wr     = wr_en && (regsel_e'(wr_sel) == SEL_CFG);
   assign pin_wr     = wr_en && (regsel_e'(wr_sel) == SEL_PIN);
   assign count_load = wr_data[COUNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         mode_q  <= '0;
         diag_q  <= 1'b0;
      end else if (cfg_wr) begin
         count_q <= wr_data[COUNT_W-1:0];
         mode_q  <= wr_data[MODE_LSB +: MODE_W];
         diag_q  <= wr_data[DIAG_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= '0;
      end else if (pin_wr) begin
         pin_q <= pinctl_t'(wr_data[1:0]);
      end
   end

   assign toggle_en = (mode_q == MODE_TOGGLE);

   logic [USED_W-1:0] cfg_view;
   assign cfg_view = {level_now, diag_q, mode_q, count_q};

   always_comb begin
      rd_data = '0;
      if (regsel_e'(rd_sel) == SEL_CFG) begin
         rd_data[USED_W-1:0] = cfg_view;
      end else begin
         rd_data[1:0] = pin_q;
      end
   end

   logic unused_ok;
   assign unused_ok = ^{wr_data[DATA_W-1:STATE_BIT]};
endmodule

// File: rtl/intout_gen.sv
module intout_gen
   import intout_pkg::*;
#(
   parameter int DIV     = 4,
   parameter int COUNT_W = 16,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              pin_o,
   output logic              pin_oe
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("intout_gen: DIV must be at least 1");
      end
      if (COUNT_W < 1) begin : g_bad_cw
         $error("intout_gen: COUNT_W must be at least 1");
      end
      if (DATA_W < COUNT_W + MODE_W + 2) begin : g_bad_dw
         $error("intout_gen: DATA_W too narrow for the configuration fields");
      end
   endgenerate

   logic               tick;
   logic               cfg_wr;
   logic [COUNT_W-1:0] count_load;
   logic [COUNT_W-1:0] count_cfg;
   logic               toggle_en;
   logic               diag_q;
   pinctl_t            pin_q;
   logic               level_q;
   logic [COUNT_W-1:0] cnt_q;
   logic               level_out;

   intout_regs #(.COUNT_W(COUNT_W), .DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .rd_sel     (rd_sel),
      .level_now  (level_out),
      .rd_data    (rd_data),
      .cfg_wr     (cfg_wr),
      .count_load (count_load),
      .count_q    (count_cfg),
      .toggle_en  (toggle_en),
      .diag_q     (diag_q),
      .pin_q      (pin_q)
   );

   intout_prescale #(.DIV(DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_wr),
      .tick_o  (tick)
   );

   intout_wavegen #(.COUNT_W(COUNT_W)) u_wave (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (cfg_wr),
      .count_load (count_load),
      .count_cfg  (count_cfg),
      .toggle_en  (toggle_en),
      .diag       (diag_q),
      .tick       (tick),
      .level_q    (level_q),
      .cnt_q      (cnt_q),
      .level_out  (level_out)
   );

   assign pin_oe = pin_q.enable & pin_q.dir_out;
   assign pin_o  = pin_oe & level_out;
endmodule

// File: rtl/intout_gen_chk.sv
module intout_gen_chk #(
   parameter int COUNT_W = 16,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               wr_sel,
   input logic [DATA_W-1:0]  wr_data,
   input logic               pin_o,
   input logic               pin_oe,
   input logic               tick,
   input logic               toggle_en,
   input logic               diag_q,
   input logic               level_q,
   input logic [COUNT_W-1:0] cnt_q,
   input logic [COUNT_W-1:0] count_cfg
);
   logic cfg_w;
   assign cfg_w = wr_en && !wr_sel;

   p_restart_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_w |=> (level_q == 1'b0 && cnt_q == $past(wr_data[COUNT_W-1:0])));

   p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!toggle_en && !cfg_w) |=> ($stable(level_q) && $stable(cnt_q)));

   p_flip_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cfg_w) |=> $stable(level_q));

   p_flip_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && toggle_en && cnt_q == '0 && !cfg_w) |=> (level_q != $past(level_q)));

   p_pin_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe |-> !pin_o);

   p_diag_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (diag_q && pin_oe) |-> pin_o);

   always @(negedge clk) begin
      if (rst_n) begin
         p_cnt_bound_r3: assert (cnt_q <= count_cfg);
      end
   end
endmodule

bind intout_gen intout_gen_chk #(.COUNT_W(COUNT_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .pin_o     (pin_o),
   .pin_oe    (pin_oe),
   .tick      (tick),
   .toggle_en (toggle_en),
   .diag_q    (diag_q),
   .level_q   (level_q),
   .cnt_q     (cnt_q),
   .count_cfg (count_cfg)
);

// File: tb/test_intout_gen.sv
module test_intout_gen;
   localparam int DIV = 3;
   localparam int CW  = 16;
   localparam int DW  = 32;
   localparam int NV  = 6;
   // {expect_toggle, mode[2:0], count[15:0]}
   localparam logic [19:0] VEC [NV] = '{
      {1'b1, 3'b111, 16'd0},
      {1'b1, 3'b111, 16'd1},
      {1'b1, 3'b111, 16'd4},
      {1'b1, 3'b111, 16'd63},
      {1'b0, 3'b011, 16'd2},
      {1'b0, 3'b000, 16'd5}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_sel = 1'b0;
   logic [DW-1:0] rd_data;
   logic          pin_o;
   logic          pin_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   intout_gen #(.DIV(DIV), .COUNT_W(CW), .DATA_W(DW)) i_intout_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_sel  (rd_sel),
      .rd_data (rd_data),
      .pin_o   (pin_o),
      .pin_oe  (pin_oe)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic rd(input bit sel, output logic [DW-1:0] d);
      rd_sel = sel;
      #1;
      d = rd_data;
   endtask

   task automatic wait_change(input int cap, output int n);
      logic last;
      last = pin_o;
      n = 0;
      while (n <= cap) begin
         @(posedge clk);
         @(negedge clk);
         n++;
         if (pin_o !== last) return;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] r;
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      rd(1'b0, r); chk(r == '0, "R1 cfg reset", r, 0);
      rd(1'b1, r); chk(r == '0, "R1 pin reset", r, 0);
      chk(pin_oe == 1'b0 && pin_o == 1'b0, "R1 pin idle", {pin_oe, pin_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      wr(1'b1, 32'h3);
      rd(1'b1, r); chk(r == 32'h3, "R9 pin readback", r, 3);

      // vector table: R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         int c;
         int half;
         c    = int'(VEC[i][15:0]);
         half = DIV * (c + 1);
         wr(1'b0, {12'h0, 1'b0, VEC[i][18:16], VEC[i][15:0]});
         if (VEC[i][19]) begin
            wait_change(4 * half, n);
            chk(n == half && pin_o == 1'b1, "R2 first inversion", n, half);
            wait_change(4 * half, n);
            chk(n == half && pin_o == 1'b0, "R3 second half period", n, half);
         end else begin
            wait_change(2 * half + 4, n);
            chk(n > 2 * half + 4 && pin_o == 1'b0, "R4 held low", n, 2 * half + 5);
         end
      end

      // R9 R5 R8: fields readback with diag set, mode 3'b010, count 0x123
      wr(1'b0, 32'h000A_0123);
      rd(1'b0, r); chk(r == 32'h001A_0123, "R9 cfg readback", r, 32'h001A_0123);
      chk(pin_o == 1'b1, "R5 diag forces high", pin_o, 1);
      repeat (10) @(negedge clk);
      chk(pin_o == 1'b1, "R5 diag stays high", pin_o, 1);

      // R8: state bit in write ignored
      wr(1'b0, 32'h0010_0005);
      rd(1'b0, r); chk(r == 32'h0000_0005, "R8 state write ignored", r, 5);
      chk(pin_o == 1'b0, "R8 level low", pin_o, 0);

      // R6: pin gating with diag forcing level high
      wr(1'b0, 32'h0008_0000);
      wr(1'b1, 32'h1);
      chk(pin_oe == 1'b0 && pin_o == 1'b0, "R6 enable only", {pin_oe, pin_o}, 0);
      wr(1'b1, 32'h2);
      chk(pin_oe == 1'b0 && pin_o == 1'b0, "R6 direction only", {pin_oe, pin_o}, 0);
      wr(1'b1, 32'h3);
      chk(pin_oe == 1'b1 && pin_o == 1'b1, "R6 both set", {pin_oe, pin_o}, 3);

      // R7: all-zero write returns power-on state
      wr(1'b0, 32'h0007_0002);
      wait_change(100, n);
      wr(1'b0, 32'h0);
      rd(1'b0, r); chk(r == '0 && pin_o == 1'b0, "R7 zero write", r, 0);
      repeat (20) @(negedge clk);
      chk(pin_o == 1'b0, "R7 stays idle", pin_o, 0);

      // R10: restart mid-period
      wr(1'b0, 32'h0007_0003);
      wait_change(100, n);
      chk(n == DIV * 4 && pin_o == 1'b1, "R10 pre-restart flip", n, DIV * 4);
      repeat (2) @(negedge clk);
      wr(1'b0, 32'h0007_0003);
      chk(pin_o == 1'b0, "R10 restart low", pin_o, 0);
      wait_change(100, n);
      chk(n == DIV * 4 && pin_o == 1'b1, "R10 full interval after restart", n, DIV * 4);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule